// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block brings a DDR SDRAM device from power-up to an operational state without help from a processor. A start pulse launches a fixed command sequence. The block first raises the clock-enable line. It then issues, in this order: precharge-all, extended-mode-register load, mode-register load with DLL reset, a second precharge-all, two auto-refresh commands, and a final mode-register load with DLL reset cleared. A programmed number of idle (NOP) cycles follows every command. When the last wait expires, a done flag goes high and stays high.

The command bus is four active-high flags (chip select, row strobe, column strobe, write enable) with an address bus and a bank bus. The mode-register contents and all wait lengths are parameters, so a system can retarget the sequence and a testbench can shorten it.

The state machine has five named states. SEQ_IDLE waits for start. SEQ_CKE raises clock-enable for one quiet cycle. SEQ_ISSUE drives the current step's command for one cycle. SEQ_WAIT holds NOP while a down-counter runs. SEQ_DONE is terminal. The transitions are:
- idle→cke on start
- cke→issue unconditionally
- issue→wait unconditionally
- wait→issue when the counter expires and steps remain, advancing the step
- wait→done when the counter expires on the last step
- done→done, until reset

The steps, in order, are STEP_PRE_A, STEP_EXT_MODE, STEP_MODE_DLL, STEP_PRE_B, STEP_REF_A, STEP_REF_B and STEP_MODE_RUN.

Top module: `ddr_init_seq`

## Requirements
- R1: While reset is asserted, and afterwards until start is sampled high, cke, all four command flags, addr, ba and done are 0.
- R2: In the cycle after start is sampled high in idle, cke is 1, no command flag is set, and addr and ba are 0. Once cke rises, it stays 1 until reset.
- R3: The commands appear in the order precharge-all, extended-mode load, mode load (DLL reset), precharge-all, refresh, refresh, mode load (run). No other commands are issued.
- R4: The command encodings are as follows. Precharge-all is {cs,ras,cas,we}=1101 with addr=0x0400 (bit 10 set) and ba=0. A mode or extended-mode load is 1111. Refresh is 1110.
- R5: The extended-mode load drives ba=1 and addr=EMR_VAL (default 0). ba returns to 0 in the following cycle.
- R6: The first mode load drives addr=MR_DLL_VAL (default 0x132) with ba=0. It is followed by MODE_WAIT (default 200) NOP cycles.
- R7: Exactly two refreshes are issued, each with addr=0 and ba=0. Each is followed by REF_WAIT (default 4) NOP cycles.
- R8: The final mode load drives addr=MR_RUN_VAL (default 0x032) with ba=0. It is followed by MODE_WAIT NOP cycles.
- R9: Every command lasts exactly one cycle. Each precharge and the extended-mode load are followed by GAP_WAIT (default 1) NOP cycles. In every NOP cycle, addr and ba are 0.
- R10: done rises in the cycle right after the final wait, and from then on stays 1 with cke=1 and NOP on the bus.
- R11: start is ignored while the sequence runs and after done, until the next reset.
- R12: A reset asserted part-way through the sequence returns all outputs to the R1 state at once. The next start runs the full sequence from its first step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins the sequence when sampled high in idle |
| cke | output | 1 | Clock enable to the memory |
| cmd_cs | output | 1 | Chip-select flag (active high) |
| cmd_ras | output | 1 | Row-strobe flag (active high) |
| cmd_cas | output | 1 | Column-strobe flag (active high) |
| cmd_we | output | 1 | Write-enable flag (active high) |
| addr | output | ADDR_W | Row/mode address bus |
| ba | output | BA_W | Bank address bus |
| done | output | 1 | High once the sequence has completed |

## Verification
The assertions check rules that must hold on every cycle:
- no command without clock-enable, and clock-enable never drops;
- single-cycle commands with an idle bus between them;
- precharge carries address bit 10, and refresh carries a zero address;
- a nonzero bank appears only with a mode load;
- done is sticky and quiet.

Only the bench's cycle-by-cycle reference comparison can show:
- the order of the seven steps and the exact mode-register values;
- the lengths of the individual waits;
- that start pulses during and after the run are ignored;
- that a reset part-way through restarts the sequence cleanly.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_CKE,
        SEQ_ISSUE,
        SEQ_WAIT,
        SEQ_DONE
    } seq_state_t;

    typedef enum logic [2:0] {
        STEP_PRE_A,
        STEP_EXT_MODE,
        STEP_MODE_DLL,
        STEP_PRE_B,
        STEP_REF_A,
        STEP_REF_B,
        STEP_MODE_RUN
    } step_t;

    typedef struct packed {
        logic cs;
        logic ras;
        logic cas;
        logic we;
    } cmd_t;

    localparam cmd_t CMD_NOP  = '{cs: 1'b0, ras: 1'b0, cas: 1'b0, we: 1'b0};
    localparam cmd_t CMD_PRE  = '{cs: 1'b1, ras: 1'b1, cas: 1'b0, we: 1'b1};
    localparam cmd_t CMD_LOAD = '{cs: 1'b1, ras: 1'b1, cas: 1'b1, we: 1'b1};
    localparam cmd_t CMD_REF  = '{cs: 1'b1, ras: 1'b1, cas: 1'b1, we: 1'b0};

endpackage

// File: rtl/ddr_init_step_rom.sv
module ddr_init_step_rom
    import ddr_init_pkg::*;
#(
    parameter int unsigned ADDR_W     = 13,
    parameter int unsigned BA_W       = 2,
    parameter int unsigned AP_BIT     = 10,
    parameter int unsigned EMR_VAL    = 0,
    parameter int unsigned MR_DLL_VAL = 'h132,
    parameter int unsigned MR_RUN_VAL = 'h032,
    parameter int unsigned GAP_WAIT   = 1,
    parameter int unsigned REF_WAIT   = 4,
    parameter int unsigned MODE_WAIT  = 200,
    parameter int unsigned CNT_W      = 8
) (
    input  step_t              step,
    output cmd_t               cmd,
    output logic [ADDR_W-1:0]  addr,
    output logic [BA_W-1:0]    ba,
    output logic [CNT_W-1:0]   wait_len,
    output logic               last
);

    localparam logic [ADDR_W-1:0] PRE_ALL_ADDR = ADDR_W'(1) << AP_BIT;
    localparam logic [BA_W-1:0]   EXT_BANK     = BA_W'(1);

    always_comb begin
        cmd      = CMD_NOP;
        addr     = '0;
        ba       = '0;
        wait_len = CNT_W'(GAP_WAIT);
        last     = 1'b0;
        unique case (step)
            STEP_PRE_A, STEP_PRE_B: begin
                cmd      = CMD_PRE;
                addr     = PRE_ALL_ADDR;
                wait_len = CNT_W'(GAP_WAIT);
            end
            STEP_EXT_MODE: begin
                cmd      = CMD_LOAD;
                addr     = ADDR_W'(EMR_VAL);
                ba       = EXT_BANK;
                wait_len = CNT_W'(GAP_WAIT);
            end
            STEP_MODE_DLL: begin
                cmd      = CMD_LOAD;
                addr     = ADDR_W'(MR_DLL_VAL);
                wait_len = CNT_W'(MODE_WAIT);
            end
            STEP_REF_A, STEP_REF_B: begin
                cmd      = CMD_REF;
                wait_len = CNT_W'(REF_WAIT);
            end
            STEP_MODE_RUN: begin
                cmd      = CMD_LOAD;
                addr     = ADDR_W'(MR_RUN_VAL);
                wait_len = CNT_W'(MODE_WAIT);
                last     = 1'b1;
            end
            default: begin
                cmd      = CMD_NOP;
            end
        endcase
    end

endmodule

// File: rtl/ddr_init_timer.sv
module ddr_init_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    // Expires in the last cycle of an N-cycle window that follows a load.
    assign expire = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
    import ddr_init_pkg::*;
#(
    parameter int unsigned ADDR_W     = 13,
    parameter int unsigned BA_W       = 2,
    parameter int unsigned AP_BIT     = 10,
    parameter int unsigned EMR_VAL    = 0,
    parameter int unsigned MR_DLL_VAL = 'h132,
    parameter int unsigned MR_RUN_VAL = 'h032,
    parameter int unsigned GAP_WAIT   = 1,
    parameter int unsigned REF_WAIT   = 4,
    parameter int unsigned MODE_WAIT  = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              cke,
    output logic              cmd_cs,
    output logic              cmd_ras,
    output logic              cmd_cas,
    output logic              cmd_we,
    output logic [ADDR_W-1:0] addr,
    output logic [BA_W-1:0]   ba,
    output logic              done
);

    localparam int unsigned MAX_SHORT = (GAP_WAIT > REF_WAIT) ? GAP_WAIT : REF_WAIT;
    localparam int unsigned MAX_WAIT  = (MAX_SHORT > MODE_WAIT) ? MAX_SHORT : MODE_WAIT;
    localparam int unsigned CNT_W     = $clog2(MAX_WAIT + 1);

    seq_state_t state_q, state_d;
    step_t      step_q, step_d;

    cmd_t              rom_cmd;
    logic [ADDR_W-1:0] rom_addr;
    logic [BA_W-1:0]   rom_ba;
    logic [CNT_W-1:0]  rom_wait;
    logic              rom_last;
    logic              wait_expire;

    ddr_init_step_rom #(
        .ADDR_W    (ADDR_W),
        .BA_W      (BA_W),
        .AP_BIT    (AP_BIT),
        .EMR_VAL   (EMR_VAL),
        .MR_DLL_VAL(MR_DLL_VAL),
        .MR_RUN_VAL(MR_RUN_VAL),
        .GAP_WAIT  (GAP_WAIT),
        .REF_WAIT  (REF_WAIT),
        .MODE_WAIT (MODE_WAIT),
        .CNT_W     (CNT_W)
    ) i_step_rom (
        .step    (step_q),
        .cmd     (rom_cmd),
        .addr    (rom_addr),
        .ba      (rom_ba),
        .wait_len(rom_wait),
        .last    (rom_last)
    );

    ddr_init_timer #(
        .CNT_W(CNT_W)
    ) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (state_q == SEQ_ISSUE),
        .load_val(rom_wait),
        .expire  (wait_expire)
    );

    // Next-state and step selection
    always_comb begin
        state_d = state_q;
        step_d  = step_q;
        unique case (state_q)
            SEQ_IDLE:  if (start) state_d = SEQ_CKE;
            SEQ_CKE:   state_d = SEQ_ISSUE;
            SEQ_ISSUE: state_d = SEQ_WAIT;
            SEQ_WAIT: begin
                if (wait_expire) begin
                    if (rom_last) begin
                        state_d = SEQ_DONE;
                    end else begin
                        state_d = SEQ_ISSUE;
                        step_d  = step_t'(3'(step_q + 3'd1));
                    end
                end
            end
            SEQ_DONE:  state_d = SEQ_DONE;
            default:   state_d = SEQ_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            step_q  <= STEP_PRE_A;
        end else begin
            state_q <= state_d;
            step_q  <= step_d;
        end
    end

    // Outputs
    always_comb begin
        cke     = 1'b0;
        cmd_cs  = 1'b0;
        cmd_ras = 1'b0;
        cmd_cas = 1'b0;
        cmd_we  = 1'b0;
        addr    = '0;
        ba      = '0;
        done    = 1'b0;
        unique case (state_q)
            SEQ_IDLE: begin
                cke = 1'b0;
            end
            SEQ_CKE, SEQ_WAIT: begin
                cke = 1'b1;
            end
            SEQ_ISSUE: begin
                cke     = 1'b1;
                cmd_cs  = rom_cmd.cs;
                cmd_ras = rom_cmd.ras;
                cmd_cas = rom_cmd.cas;
                cmd_we  = rom_cmd.we;
                addr    = rom_addr;
                ba      = rom_ba;
            end
            SEQ_DONE: begin
                cke  = 1'b1;
                done = 1'b1;
            end
            default: begin
                cke = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/ddr_init_chk.sv
module ddr_init_chk #(
    parameter int unsigned ADDR_W = 13,
    parameter int unsigned BA_W   = 2,
    parameter int unsigned AP_BIT = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cke,
    input logic              cmd_cs,
    input logic              cmd_ras,
    input logic              cmd_cas,
    input logic              cmd_we,
    input logic [ADDR_W-1:0] addr,
    input logic [BA_W-1:0]   ba,
    input logic              done
);

    a_r2_cke_holds: assert property (@(posedge clk) disable iff (!rst_n)
        cke |=> cke);

    a_r2_no_cmd_without_cke: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_cs |-> cke);

    a_r2_first_cke_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |-> !cmd_cs);

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_cs |=> !cmd_cs);

    a_r9_nop_bus_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_cs |-> (addr == '0 && ba == '0 && !cmd_ras && !cmd_cas && !cmd_we));

    a_r4_precharge_all: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_cs && cmd_ras && !cmd_cas && cmd_we) |-> (addr[AP_BIT] && ba == '0));

    a_r7_refresh_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_cs && cmd_ras && cmd_cas && !cmd_we) |-> (addr == '0 && ba == '0));

    a_r5_bank_only_on_load: assert property (@(posedge clk) disable iff (!rst_n)
        (ba != '0) |-> (cmd_cs && cmd_ras && cmd_cas && cmd_we));

    a_r10_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

    a_r10_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cke && !cmd_cs));

    a_r1_idle_no_done: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> (!done && !cmd_cs));

endmodule

bind ddr_init_seq ddr_init_chk #(
    .ADDR_W(ADDR_W),
    .BA_W  (BA_W),
    .AP_BIT(AP_BIT)
) i_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cke    (cke),
    .cmd_cs (cmd_cs),
    .cmd_ras(cmd_ras),
    .cmd_cas(cmd_cas),
    .cmd_we (cmd_we),
    .addr   (addr),
    .ba     (ba),
    .done   (done)
);

// File: tb/test_ddr_init_seq.sv
module test_ddr_init_seq;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 13;
    localparam int BA_W       = 2;
    localparam int GAP_W      = 1;
    localparam int REF_W      = 4;
    localparam int MODE_W     = 200;
    localparam int VEC_W      = 1 + 4 + ADDR_W + BA_W + 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              cke, cmd_cs, cmd_ras, cmd_cas, cmd_we, done;
    logic [ADDR_W-1:0] addr;
    logic [BA_W-1:0]   ba;

    int checks = 0;
    int errors = 0;

    logic [VEC_W-1:0] exp_q[$];
    string            tag_q[$];

    ddr_init_seq i_ddr_init_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .cke    (cke),
        .cmd_cs (cmd_cs),
        .cmd_ras(cmd_ras),
        .cmd_cas(cmd_cas),
        .cmd_we (cmd_we),
        .addr   (addr),
        .ba     (ba),
        .done   (done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [VEC_W-1:0] mk(input logic k, input logic [3:0] c,
                                            input int a, input int b, input logic d);
        return {k, c, ADDR_W'(a), BA_W'(b), d};
    endfunction

    task automatic check(input logic [VEC_W-1:0] expv, input string tag);
        logic [VEC_W-1:0] act;
        act = {cke, cmd_cs, cmd_ras, cmd_cas, cmd_we, addr, ba, done};
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, expv);
        end
    endtask

    // Reference model: the expected per-cycle trace after start is sampled
    task automatic build_model();
        logic [3:0] c;
        int a, b, w;
        string t, wt;
        exp_q.delete();
        tag_q.delete();
        exp_q.push_back(mk(1'b1, 4'b0000, 0, 0, 1'b0)); tag_q.push_back("R2");
        for (int k = 0; k < 7; k++) begin
            b = 0;
            case (k)
                0, 3: begin c = 4'b1101; a = 'h400; w = GAP_W;  t = (k == 0) ? "R4" : "R3"; wt = "R9"; end
                1:    begin c = 4'b1111; a = 0;     b = 1; w = GAP_W; t = "R5"; wt = "R5"; end
                2:    begin c = 4'b1111; a = 'h132; w = MODE_W; t = "R6"; wt = "R6"; end
                4, 5: begin c = 4'b1110; a = 0;     w = REF_W;  t = "R7"; wt = "R7"; end
                default: begin c = 4'b1111; a = 'h032; w = MODE_W; t = "R8"; wt = "R8"; end
            endcase
            exp_q.push_back(mk(1'b1, c, a, b, 1'b0)); tag_q.push_back(t);
            for (int n = 0; n < w; n++) begin
                exp_q.push_back(mk(1'b1, 4'b0000, 0, 0, 1'b0)); tag_q.push_back(wt);
            end
        end
    endtask

    // Run the sequence; hold keeps start high (R11); stop_at>0 aborts early.
    task automatic run_seq(input bit hold, input int stop_at);
        build_model();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        if (!hold) start = 1'b0;
        for (int i = 0; i < exp_q.size(); i++) begin
            check(exp_q[i], tag_q[i]);
            if (stop_at > 0 && i == stop_at) return;
            if (i == 40) start = 1'b1;
            if (i == 41 && !hold) start = 1'b0;
            @(negedge clk);
        end
        for (int i = 0; i < 6; i++) begin
            check(mk(1'b1, 4'b0000, 0, 0, 1'b1), "R10");
            start = (i % 2 == 0);
            @(negedge clk);
        end
        start = 1'b0;
        for (int i = 0; i < 4; i++) begin
            check(mk(1'b1, 4'b0000, 0, 0, 1'b1), "R11");
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1: reset and idle without start
        repeat (2) @(negedge clk);
        check(mk(1'b0, 4'b0000, 0, 0, 1'b0), "R1");
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(mk(1'b0, 4'b0000, 0, 0, 1'b0), "R1");
        end

        // Full sequence with single start pulse
        run_seq(1'b0, 0);

        // R12: reset in the middle, then rerun with start held high
        rst_n = 1'b0;
        @(negedge clk);
        check(mk(1'b0, 4'b0000, 0, 0, 1'b0), "R12");
        rst_n = 1'b1;
        @(negedge clk);
        check(mk(1'b0, 4'b0000, 0, 0, 1'b0), "R12");
        run_seq(1'b0, 120);
        rst_n = 1'b0;
        #1;
        check(mk(1'b0, 4'b0000, 0, 0, 1'b0), "R12");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(mk(1'b0, 4'b0000, 0, 0, 1'b0), "R12");
        run_seq(1'b1, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule